// File: doc/BRIEF.md
# Flash High-Voltage Pulse Sequencer

This block times the high-voltage enable of a flash array while cells are being programmed or erased. A start strobe launches an operation. An operation-select input chooses program or erase, and it is taken at the same edge as the strobe. The block then issues enable pulses of fixed width. Each pulse is followed by a fixed recovery gap, and at the end of that gap an external verify result is sampled. Once verify first reports success after `n` pulses, the block adds `n` more pulses with the same timing, which gives the cell a one-hundred-percent margin. It then reports completion. If the pulse budget for the operation runs out before verify succeeds, the block reports failure and adds no margin pulses.

Each operation has its own pulse width, recovery gap and pulse limit. Widths and gaps are given in microseconds and turned into clock cycles through a clock-frequency parameter (in MHz). By default a program pulse is 25 us with a 10 us gap and a limit of 50 pulses. An erase pulse is 100 ms with a 1 ms gap and a limit of 5 pulses. An optional elaboration check keeps the timing inside the allowed windows: program pulse 20 to 25 us, erase pulse 90 to 110 ms.

Top module: `hv_pulse_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, enable, done and fail are low and the pulse count is 0.
- R2: A start strobe seen at a clock edge while idle is accepted. Busy is high from the next cycle until the operation finishes.
- R3: Each pulse keeps the enable high for exactly W cycles, where W is the selected operation's pulse width in microseconds times the clock frequency in MHz. The first pulse starts in the cycle right after the accepting edge.
- R4: After each pulse the enable stays low for exactly S recovery cycles (S from that operation's gap). Verify is sampled only at the edge that closes the last recovery cycle.
- R5: The pulse count clears to 0 when a start is accepted and goes up by one at the edge that ends each pulse, margin pulses included. After the operation ends it holds its final value until the next accepted start.
- R6: When verify is first seen high after n pulses, exactly n more pulses follow with the same width and gap, and verify is ignored while they run. Done is then raised with a final count of 2n.
- R7: When verify is low at the decision after pulse number MAX, fail is raised with a final count of MAX and no margin pulse is issued. MAX is 50 for program and 5 for erase by default.
- R8: When verify first passes at the decision after pulse number MAX, the pass wins over the limit: the margin phase of MAX pulses runs and the operation ends with done, not fail.
- R9: A start strobe while busy is ignored, and so is any change of the operation-select input during an operation. Timing, count and result stay those of the operation that was accepted.
- R10: Done and fail are one-cycle pulses that never occur together, and busy is low in that cycle. A start given in that same cycle is accepted.
- R11: Operation select 0 chooses program and 1 chooses erase. Each uses its own width, gap and limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency given by CLK_MHZ |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_erase_i | input | 1 | Operation select: 0 program, 1 erase |
| verify_ok_i | input | 1 | Verify result, sampled at the end of each recovery gap |
| hv_en_o | output | 1 | High-voltage pulse enable |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle success indication |
| fail_o | output | 1 | One-cycle pulse-limit failure indication |
| pulse_count_o | output | CNT_W | Pulses issued in the current or last operation |

## Verification
Two outcomes can fall on the same decision edge: verify passing for the first time, and the pulse counter reaching the operation's limit. The bench provokes this by making verify pass exactly after pulse 50 of a program and after pulse 5 of an erase. It judges the result with its reference model, which expects a full margin run of equal length and then done, not fail. A second overlap is also driven: completion and a new start in the same cycle. Here the bench issues the next operation's strobe in the done or fail cycle and expects the new operation's first pulse in the very next cycle.

// File: rtl/hvs_pkg.sv
package hvs_pkg;

   typedef enum logic [1:0] {
      SQ_IDLE   = 2'd0,
      SQ_PULSE  = 2'd1,
      SQ_SETTLE = 2'd2
   } sq_state_e;

   typedef enum logic {
      OP_PROGRAM = 1'b0,
      OP_ERASE   = 1'b1
   } hv_op_e;

   function automatic int bits_for(input longint unsigned v);
      return (v < 2) ? 1 : $clog2(v + 1);
   endfunction

   function automatic longint unsigned max_u(input longint unsigned a,
                                             input longint unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/hvs_op_table.sv
module hvs_op_table
   import hvs_pkg::*;
#(
   parameter int CLK_MHZ        = 100,
   parameter int PGM_PULSE_US   = 25,
   parameter int PGM_SETTLE_US  = 10,
   parameter int PGM_MAX        = 50,
   parameter int ERS_PULSE_US   = 100000,
   parameter int ERS_SETTLE_US  = 1000,
   parameter int ERS_MAX        = 5,
   parameter bit STRICT_RANGE   = 1'b1,
   parameter int TW             = 24,
   parameter int CW             = 7
) (
   input  logic          op_i,
   output logic [TW-1:0] pulse_m1_o,
   output logic [TW-1:0] settle_m1_o,
   output logic [CW-1:0] max_pulses_o
);

   localparam longint unsigned PGM_PULSE_CYC  = longint'(PGM_PULSE_US)  * CLK_MHZ;
   localparam longint unsigned PGM_SETTLE_CYC = longint'(PGM_SETTLE_US) * CLK_MHZ;
   localparam longint unsigned ERS_PULSE_CYC  = longint'(ERS_PULSE_US)  * CLK_MHZ;
   localparam longint unsigned ERS_SETTLE_CYC = longint'(ERS_SETTLE_US) * CLK_MHZ;

   // elaboration-time parameter checks
   if (CLK_MHZ < 1) begin : g_bad_clk
      $error("hvs_op_table: CLK_MHZ must be at least 1");
   end
   if (PGM_PULSE_US < 1 || PGM_SETTLE_US < 1 || ERS_PULSE_US < 1 || ERS_SETTLE_US < 1)
   begin : g_bad_time
      $error("hvs_op_table: pulse widths and gaps must be nonzero");
   end
   if (PGM_MAX < 1 || ERS_MAX < 1) begin : g_bad_max
      $error("hvs_op_table: pulse limits must be nonzero");
   end
   if (bits_for(max_u(max_u(PGM_PULSE_CYC, PGM_SETTLE_CYC),
                      max_u(ERS_PULSE_CYC, ERS_SETTLE_CYC)) - 1) > TW) begin : g_bad_tw
      $error("hvs_op_table: timer width too small");
   end
   if (bits_for(2 * max_u(PGM_MAX, ERS_MAX)) > CW) begin : g_bad_cw
      $error("hvs_op_table: counter width too small");
   end

   // optional window check on the device timing limits
   if (STRICT_RANGE) begin : g_strict
      if (PGM_PULSE_US < 20 || PGM_PULSE_US > 25) begin : g_pgm_win
         $error("hvs_op_table: program pulse outside 20..25 us");
      end
      if (ERS_PULSE_US < 90000 || ERS_PULSE_US > 110000) begin : g_ers_win
         $error("hvs_op_table: erase pulse outside 90..110 ms");
      end
      if (PGM_MAX > 50 || ERS_MAX > 5) begin : g_lim
         $error("hvs_op_table: pulse limit above device allowance");
      end
   end

   always_comb begin
      if (hv_op_e'(op_i) == OP_ERASE) begin
         pulse_m1_o   = TW'(ERS_PULSE_CYC - 1);
         settle_m1_o  = TW'(ERS_SETTLE_CYC - 1);
         max_pulses_o = CW'(ERS_MAX);
      end else begin
         pulse_m1_o   = TW'(PGM_PULSE_CYC - 1);
         settle_m1_o  = TW'(PGM_SETTLE_CYC - 1);
         max_pulses_o = CW'(PGM_MAX);
      end
   end

endmodule

// File: rtl/hvs_timer.sv
module hvs_timer #(
   parameter int TW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] load_val_i,
   output logic          zero_o
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign zero_o = (cnt_q == '0);

   AST_TIMER_LOADS_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (cnt_q == $past(load_val_i)));   // R3

endmodule

// File: rtl/hvs_tally.sv
module hvs_tally #(
   parameter int CW      = 7,
   parameter int CNT_MAX = 100
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          pulse_end_i,
   input  logic          margin_load_i,
   input  logic          margin_step_i,
   output logic [CW-1:0] pulse_cnt_o,
   output logic          margin_last_o
);

   logic [CW-1:0] pulse_q;
   logic [CW-1:0] margin_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pulse_q <= '0;
      end else if (clr_i) begin
         pulse_q <= '0;
      end else if (pulse_end_i) begin
         pulse_q <= pulse_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         margin_q <= '0;
      end else if (clr_i) begin
         margin_q <= '0;
      end else if (margin_load_i) begin
         margin_q <= pulse_q;
      end else if (margin_step_i) begin
         margin_q <= margin_q - 1'b1;
      end
   end

   assign pulse_cnt_o   = pulse_q;
   assign margin_last_o = (margin_q == CW'(1));

   AST_MARGIN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      margin_step_i |-> (margin_q > CW'(1)));   // R6

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_q <= CW'(CNT_MAX));   // R5

   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_end_i && !clr_i |=> (pulse_q == $past(pulse_q) + 1'b1));   // R5

endmodule

// File: rtl/hvs_ctrl.sv
module hvs_ctrl
   import hvs_pkg::*;
#(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic          op_i,
   input  logic          verify_i,
   input  logic          t_zero_i,
   input  logic [CW-1:0] pulse_cnt_i,
   input  logic [CW-1:0] max_pulses_i,
   input  logic          margin_last_i,
   output logic          op_sel_o,
   output logic          t_load_o,
   output logic          t_pick_pulse_o,
   output logic          clr_o,
   output logic          pulse_end_o,
   output logic          margin_load_o,
   output logic          margin_step_o,
   output logic          hv_en_o,
   output logic          busy_o,
   output logic          done_o,
   output logic          fail_o
);

   sq_state_e state_q, state_d;
   hv_op_e    op_q, op_d;
   logic      margin_q, margin_d;
   logic      done_q, done_d;
   logic      fail_q, fail_d;

   always_comb begin
      state_d        = state_q;
      op_d           = op_q;
      margin_d       = margin_q;
      done_d         = 1'b0;
      fail_d         = 1'b0;
      t_load_o       = 1'b0;
      t_pick_pulse_o = 1'b1;
      clr_o          = 1'b0;
      pulse_end_o    = 1'b0;
      margin_load_o  = 1'b0;
      margin_step_o  = 1'b0;
      unique case (state_q)
         SQ_PULSE: begin
            if (t_zero_i) begin
               state_d        = SQ_SETTLE;
               t_load_o       = 1'b1;
               t_pick_pulse_o = 1'b0;
               pulse_end_o    = 1'b1;
            end
         end
         SQ_SETTLE: begin
            if (t_zero_i) begin
               if (margin_q) begin
                  if (margin_last_i) begin
                     state_d = SQ_IDLE;
                     done_d  = 1'b1;
                  end else begin
                     margin_step_o = 1'b1;
                     state_d       = SQ_PULSE;
                     t_load_o      = 1'b1;
                  end
               end else if (verify_i) begin
                  margin_load_o = 1'b1;
                  margin_d      = 1'b1;
                  state_d       = SQ_PULSE;
                  t_load_o      = 1'b1;
               end else if (pulse_cnt_i == max_pulses_i) begin
                  state_d = SQ_IDLE;
                  fail_d  = 1'b1;
               end else begin
                  state_d  = SQ_PULSE;
                  t_load_o = 1'b1;
               end
            end
         end
         default: begin
            state_d = SQ_IDLE;
            if (start_i) begin
               state_d  = SQ_PULSE;
               op_d     = hv_op_e'(op_i);
               margin_d = 1'b0;
               t_load_o = 1'b1;
               clr_o    = 1'b1;
            end
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q  <= SQ_IDLE;
         op_q     <= OP_PROGRAM;
         margin_q <= 1'b0;
         done_q   <= 1'b0;
         fail_q   <= 1'b0;
      end else begin
         state_q  <= state_d;
         op_q     <= op_d;
         margin_q <= margin_d;
         done_q   <= done_d;
         fail_q   <= fail_d;
      end
   end

   assign op_sel_o = (state_q == SQ_IDLE) ? op_i : op_q;
   assign hv_en_o  = (state_q == SQ_PULSE);
   assign busy_o   = (state_q != SQ_IDLE);
   assign done_o   = done_q;
   assign fail_o   = fail_q;

   AST_HV_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      hv_en_o |-> busy_o);   // R3

   AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |-> (!busy_o && !(done_o && fail_o)));   // R10

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o || fail_o) |=> !(done_o || fail_o));   // R10

   AST_FAIL_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> $past(pulse_cnt_i == max_pulses_i));   // R7

   AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && $past(busy_o) |-> $stable(op_q));   // R9

endmodule

// File: rtl/hv_pulse_seq.sv
module hv_pulse_seq
   import hvs_pkg::*;
#(
   parameter int CLK_MHZ       = 100,
   parameter int PGM_PULSE_US  = 25,
   parameter int PGM_SETTLE_US = 10,
   parameter int PGM_MAX       = 50,
   parameter int ERS_PULSE_US  = 100000,
   parameter int ERS_SETTLE_US = 1000,
   parameter int ERS_MAX       = 5,
   parameter bit STRICT_RANGE  = 1'b1,
   localparam int CNT_MAX      = 2 * int'(max_u(PGM_MAX, ERS_MAX)),
   localparam int CNT_W        = bits_for(CNT_MAX)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_erase_i,
   input  logic             verify_ok_i,
   output logic             hv_en_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             fail_o,
   output logic [CNT_W-1:0] pulse_count_o
);

   localparam longint unsigned LONGEST_CYC =
      max_u(max_u(longint'(PGM_PULSE_US), longint'(PGM_SETTLE_US)),
            max_u(longint'(ERS_PULSE_US), longint'(ERS_SETTLE_US))) * CLK_MHZ;
   localparam int TIMER_W = bits_for(LONGEST_CYC - 1);

   logic               op_sel;
   logic [TIMER_W-1:0] pulse_m1, settle_m1, t_load_val;
   logic [CNT_W-1:0]   max_pulses, pulse_cnt;
   logic               t_load, t_pick_pulse, t_zero;
   logic               clr, pulse_end, margin_load, margin_step, margin_last;

   hvs_op_table #(
      .CLK_MHZ      (CLK_MHZ),
      .PGM_PULSE_US (PGM_PULSE_US),
      .PGM_SETTLE_US(PGM_SETTLE_US),
      .PGM_MAX      (PGM_MAX),
      .ERS_PULSE_US (ERS_PULSE_US),
      .ERS_SETTLE_US(ERS_SETTLE_US),
      .ERS_MAX      (ERS_MAX),
      .STRICT_RANGE (STRICT_RANGE),
      .TW           (TIMER_W),
      .CW           (CNT_W)
   ) u_table (
      .op_i        (op_sel),
      .pulse_m1_o  (pulse_m1),
      .settle_m1_o (settle_m1),
      .max_pulses_o(max_pulses)
   );

   assign t_load_val = t_pick_pulse ? pulse_m1 : settle_m1;

   hvs_timer #(.TW(TIMER_W)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    (t_load),
      .load_val_i(t_load_val),
      .zero_o    (t_zero)
   );

   hvs_tally #(.CW(CNT_W), .CNT_MAX(CNT_MAX)) u_tally (
      .clk          (clk),
      .rst_n        (rst_n),
      .clr_i        (clr),
      .pulse_end_i  (pulse_end),
      .margin_load_i(margin_load),
      .margin_step_i(margin_step),
      .pulse_cnt_o  (pulse_cnt),
      .margin_last_o(margin_last)
   );

   hvs_ctrl #(.CW(CNT_W)) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .op_i          (op_erase_i),
      .verify_i      (verify_ok_i),
      .t_zero_i      (t_zero),
      .pulse_cnt_i   (pulse_cnt),
      .max_pulses_i  (max_pulses),
      .margin_last_i (margin_last),
      .op_sel_o      (op_sel),
      .t_load_o      (t_load),
      .t_pick_pulse_o(t_pick_pulse),
      .clr_o         (clr),
      .pulse_end_o   (pulse_end),
      .margin_load_o (margin_load),
      .margin_step_o (margin_step),
      .hv_en_o       (hv_en_o),
      .busy_o        (busy_o),
      .done_o        (done_o),
      .fail_o        (fail_o)
   );

   assign pulse_count_o = pulse_cnt;

   AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      start_i && !busy_o |=> busy_o && hv_en_o);   // R2

   AST_IDLE_NO_HV: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !hv_en_o);   // R4

endmodule

// File: tb/sim_hv_pulse_seq.sv
module sim_hv_pulse_seq;

   localparam int W_P = 25, S_P = 10, M_P = 50;
   localparam int W_E = 40, S_E = 6,  M_E = 5;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst_n, start_i, op_erase_i, verify_ok_i;
   logic       hv_en_o, busy_o, done_o, fail_o;
   logic [6:0] pulse_count_o;

   hv_pulse_seq #(
      .CLK_MHZ(1), .PGM_PULSE_US(W_P), .PGM_SETTLE_US(S_P), .PGM_MAX(M_P),
      .ERS_PULSE_US(W_E), .ERS_SETTLE_US(S_E), .ERS_MAX(M_E), .STRICT_RANGE(1'b0)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
      .verify_ok_i(verify_ok_i), .hv_en_o(hv_en_o), .busy_o(busy_o),
      .done_o(done_o), .fail_o(fail_o), .pulse_count_o(pulse_count_o)
   );

   int    checks = 0, errors = 0;
   bit    finished = 1'b0;
   string tag = "R1";

   // reference model state: operation timeline measured from first busy cycle
   bit m_run = 1'b0, m_pass = 1'b0;
   int m_rel = 0, m_L = 0, m_tot = 0, m_W = 1, m_S = 1, m_P = 1, m_last = 0;

   task automatic chk(input string req, input string sig, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s [%s] %s rel=%0d act=%0d exp=%0d", req, tag, sig, m_rel, act, exp);
      end
   endtask

   function automatic int pulses_done(input int rel);
      int k, r, c;
      k = rel / (m_W + m_S);
      r = rel % (m_W + m_S);
      c = k + ((r >= m_W) ? 1 : 0);
      return (c > m_tot) ? m_tot : c;
   endfunction

   task automatic compare();
      int b, hv, d, f, c;
      if (m_run) begin
         b  = (m_rel < m_L) ? 1 : 0;
         hv = (b == 1 && (m_rel % (m_W + m_S)) < m_W) ? 1 : 0;
         d  = (m_rel == m_L && m_pass) ? 1 : 0;
         f  = (m_rel == m_L && !m_pass) ? 1 : 0;
         c  = pulses_done(m_rel);
      end else begin
         b = 0; hv = 0; d = 0; f = 0; c = m_last;
      end
      chk("R2", "busy", int'(busy_o), b);
      chk((b == 1 && hv == 0) ? "R4" : "R3", "hv_en", int'(hv_en_o), hv);
      chk("R6", "done", int'(done_o), d);
      chk("R7", "fail", int'(fail_o), f);
      chk("R5", "pulse_count", int'(pulse_count_o), c);
   endtask

   // one cycle: check at negedge, drive, advance model at posedge
   task automatic tick(input bit st, input bit op, input int p);
      bit busy_m;
      compare();
      start_i    = st;
      op_erase_i = op;
      busy_m     = m_run && (m_rel < m_L);
      if (busy_m)
         verify_ok_i = (m_rel < m_P * (m_W + m_S)) ? (pulses_done(m_rel) >= m_P) : 1'b0;
      else
         verify_ok_i = 1'b1;
      @(posedge clk);
      if (st && !busy_m) begin
         m_run  = 1'b1;
         m_rel  = 0;
         m_W    = op ? W_E : W_P;
         m_S    = op ? S_E : S_P;
         m_P    = p;
         m_pass = (p <= (op ? M_E : M_P));
         m_tot  = m_pass ? 2 * p : (op ? M_E : M_P);
         m_L    = m_tot * (m_W + m_S);
      end else if (busy_m) begin
         m_rel++;
      end else begin
         if (m_run) m_last = m_tot;
         m_run = 1'b0;
      end
      @(negedge clk);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1);
   endtask

   task automatic run_op(input bit op, input int p, input bit noisy, input string t);
      tag = t;
      tick(1'b1, op, p);
      while (m_run && m_rel < m_L)
         tick(noisy && (m_rel % 5 == 2), noisy ? ~op : op, 1);
   endtask

   initial begin
      rst_n = 1'b0; start_i = 1'b1; op_erase_i = 1'b0; verify_ok_i = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      tag = "R1 reset";
      compare();
      start_i = 1'b0;
      rst_n   = 1'b1;
      idle(2);
      run_op(1'b0, 1,    1'b0, "R11 program, first pass");
      idle(3);
      run_op(1'b0, 3,    1'b1, "R9 start and op toggles while busy");
      run_op(1'b0, 1000, 1'b0, "R7 program limit, R10 start in end cycle");
      idle(2);
      run_op(1'b0, M_P,  1'b0, "R8 program pass at limit");
      idle(1);
      run_op(1'b1, 2,    1'b0, "R11 erase");
      run_op(1'b1, M_E,  1'b1, "R8 erase pass at limit");
      run_op(1'b1, 1000, 1'b0, "R7 erase limit");
      idle(4);
      run_op(1'b0, 2,    1'b1, "R10 final program");
      idle(3);
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog act=running exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule